// File: doc/BRIEF.md
# Per-Bank DRAM Timing Tracker

This block tells a separate DRAM command scheduler which commands are legal right now. It publishes four permission masks, one each for precharge, activate, read and write, with one bit per bank. The scheduler reads these masks, picks a command and issues it. The block then sees the command that was actually issued, given as a type code and a bank index, and reloads the down-counters that the command starts. It only advises: it never chooses or blocks a command itself.

Each timing parameter is an input that software programs, so nothing is fixed at build time. The block samples a parameter's value in the cycle the command that uses it is issued. Each bank has four counters:

- an activate-to-column counter,
- an active-minimum counter,
- a precharge-recovery counter,
- a write-recovery counter.

Two counters are shared by all banks:

- an activate-to-activate spacing counter,
- a column-to-column spacing counter.

A permission bit is high only when every counter that gates that command for that bank has drained to zero.

Top module: `dram_timing_tracker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, all bits of `ok_pre`, `ok_act`, `ok_rd` and `ok_wr` are 1. Reset applied in the middle of activity clears every pending wait.
- R2: When an activate (code 1) is issued to bank b with `t_rcd` = T ≥ 2, `ok_rd[b]` and `ok_wr[b]` are 0 for the first T−1 cycles after the issue edge and are 1 from cycle T on. The read and write bits of other banks are unaffected.
- R3: An activate issued to bank b with `t_ras` = T ≥ 2 holds `ok_pre[b]` at 0 in the same way.
- R4: When a precharge (code 2) is issued to bank b with `t_rp` = T ≥ 2, `ok_act[b]` is 0 until cycle T.
- R5: When a write (code 4) is issued to bank b with `t_wr` = T ≥ 2, `ok_pre[b]` is 0 until cycle T.
- R6: An activate to any bank with `t_rrd` = T ≥ 2 clears every bit of `ok_act` until cycle T.
- R7: A read (code 3) or a write to any bank with `t_ccd` = T ≥ 2 clears every bit of `ok_rd` and `ok_wr` until cycle T.
- R8: A timing value of 0 or 1 gates nothing: the command it governs is allowed in the very next cycle.
- R9: A permission bit is 1 only when all of its gating counters are zero. For example, `ok_pre[b]` needs both the active-minimum wait and the write-recovery wait for bank b to have expired.
- R10: When a counter that is still running is reloaded, it keeps the longer of its remaining wait and the new wait.
- R11: Code 0 (no command) and the unused codes 5 to 7 load no counter. With no command issued, no permission bit falls.
- R12: A timing parameter is sampled only at the issue edge. Changing it afterwards does not change a wait that is already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_type | input | 3 | Issued command: 0 none, 1 activate, 2 precharge, 3 read, 4 write, 5 to 7 ignored |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank of the issued command |
| t_rcd | input | TIMER_W | Activate to read/write delay, in cycles |
| t_rp | input | TIMER_W | Precharge to activate delay |
| t_ras | input | TIMER_W | Activate to precharge minimum |
| t_wr | input | TIMER_W | Write to precharge recovery |
| t_rrd | input | TIMER_W | Activate to activate spacing, all banks |
| t_ccd | input | TIMER_W | Column command spacing, all banks |
| ok_pre | output | NUM_BANKS | Precharge allowed, one bit per bank |
| ok_act | output | NUM_BANKS | Activate allowed, one bit per bank |
| ok_rd | output | NUM_BANKS | Read allowed, one bit per bank |
| ok_wr | output | NUM_BANKS | Write allowed, one bit per bank |

## Verification
The bench watches the exact cycle in which each permission bit returns. A counter that is off by one would free the command a cycle early or a cycle late, and that shows up at cycle T−1 or at cycle T.

Several other faults are also targeted:
- A bank where both the write-recovery wait and the active-minimum wait overlap, which catches a precharge permission that ignores one of its two gates.
- A reload with a shorter value while a wait is still running, which catches a design that simply overwrites the counter and frees the command too soon.
- A timing parameter changed right after issue, which catches logic that reads the parameter live instead of at the issue edge.
- Timing values of 0 and 1, which catch a stray one-cycle stall.
- The unused command codes, which catch a decoder that loads counters for them.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4
    } cmd_e;

    // One-hot view of the command seen at a given bank or globally.
    typedef struct packed {
        logic act;
        logic pre;
        logic rd;
        logic wr;
    } issue_t;

    // Programmed waits that a bank samples when a command hits it.
    typedef struct packed {
        logic [15:0] rcd;
        logic [15:0] ras;
        logic [15:0] rp;
        logic [15:0] wr;
    } bank_wait_t;

    function automatic cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_ACT;
            3'd2:    return CMD_PRE;
            3'd3:    return CMD_RD;
            3'd4:    return CMD_WR;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic issue_t to_issue(input cmd_e c);
        issue_t r;
        r.act = (c == CMD_ACT);
        r.pre = (c == CMD_PRE);
        r.rd  = (c == CMD_RD);
        r.wr  = (c == CMD_WR);
        return r;
    endfunction

endpackage

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] wait_cycles,
    output logic         idle
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_dec;
    logic [W-1:0] cnt_init;
    logic [W-1:0] cnt_next;

    always_comb begin
        cnt_dec  = (cnt == '0) ? '0 : cnt - 1'b1;
        cnt_init = (wait_cycles > W'(1)) ? wait_cycles - 1'b1 : '0;
        if (load)
            cnt_next = (cnt_init > cnt_dec) ? cnt_init : cnt_dec;
        else
            cnt_next = cnt_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end

    assign idle = (cnt == '0);
endmodule

// File: rtl/tt_bank_gate.sv
module tt_bank_gate #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  tt_pkg::issue_t hit,
    input  logic [W-1:0] w_rcd,
    input  logic [W-1:0] w_ras,
    input  logic [W-1:0] w_rp,
    input  logic [W-1:0] w_wr,
    input  logic         act_space_idle,
    input  logic         col_space_idle,
    output logic         pre_ok,
    output logic         act_ok,
    output logic         rd_ok,
    output logic         wr_ok
);
    logic rcd_idle, ras_idle, rp_idle, wr_idle;

    tt_down_counter #(.W(W)) u_rcd (
        .clk(clk), .rst(rst), .load(hit.act), .wait_cycles(w_rcd), .idle(rcd_idle));
    tt_down_counter #(.W(W)) u_ras (
        .clk(clk), .rst(rst), .load(hit.act), .wait_cycles(w_ras), .idle(ras_idle));
    tt_down_counter #(.W(W)) u_rp (
        .clk(clk), .rst(rst), .load(hit.pre), .wait_cycles(w_rp), .idle(rp_idle));
    tt_down_counter #(.W(W)) u_wr (
        .clk(clk), .rst(rst), .load(hit.wr), .wait_cycles(w_wr), .idle(wr_idle));

    always_comb begin
        pre_ok = ras_idle & wr_idle;
        act_ok = rp_idle & act_space_idle;
        rd_ok  = rcd_idle & col_space_idle;
        wr_ok  = rcd_idle & col_space_idle;
    end
endmodule

// File: rtl/dram_timing_tracker.sv
module dram_timing_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int TIMER_W   = 6,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_type,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [TIMER_W-1:0]   t_rcd,
    input  logic [TIMER_W-1:0]   t_rp,
    input  logic [TIMER_W-1:0]   t_ras,
    input  logic [TIMER_W-1:0]   t_wr,
    input  logic [TIMER_W-1:0]   t_rrd,
    input  logic [TIMER_W-1:0]   t_ccd,
    output logic [NUM_BANKS-1:0] ok_pre,
    output logic [NUM_BANKS-1:0] ok_act,
    output logic [NUM_BANKS-1:0] ok_rd,
    output logic [NUM_BANKS-1:0] ok_wr
);
    import tt_pkg::*;

    issue_t any_issue;
    logic   act_space_idle;
    logic   col_space_idle;

    assign any_issue = to_issue(decode_cmd(cmd_type));

    // Shared spacing counters, one per chip-wide constraint.
    tt_down_counter #(.W(TIMER_W)) u_act_space (
        .clk(clk), .rst(rst), .load(any_issue.act),
        .wait_cycles(t_rrd), .idle(act_space_idle));

    tt_down_counter #(.W(TIMER_W)) u_col_space (
        .clk(clk), .rst(rst), .load(any_issue.rd | any_issue.wr),
        .wait_cycles(t_ccd), .idle(col_space_idle));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        issue_t bank_hit;
        assign bank_hit = (cmd_bank == BANK_W'(b)) ? any_issue : '0;

        tt_bank_gate #(.W(TIMER_W)) u_gate (
            .clk(clk), .rst(rst), .hit(bank_hit),
            .w_rcd(t_rcd), .w_ras(t_ras), .w_rp(t_rp), .w_wr(t_wr),
            .act_space_idle(act_space_idle), .col_space_idle(col_space_idle),
            .pre_ok(ok_pre[b]), .act_ok(ok_act[b]),
            .rd_ok(ok_rd[b]), .wr_ok(ok_wr[b]));
    end
endmodule

// File: rtl/dram_timing_tracker_checker.sv
module dram_timing_tracker_checker #(
    parameter int NUM_BANKS = 4,
    parameter int TIMER_W   = 6,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           cmd_type,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [TIMER_W-1:0]   t_rcd,
    input logic [TIMER_W-1:0]   t_rp,
    input logic [TIMER_W-1:0]   t_ras,
    input logic [TIMER_W-1:0]   t_wr,
    input logic [TIMER_W-1:0]   t_rrd,
    input logic [TIMER_W-1:0]   t_ccd,
    input logic [NUM_BANKS-1:0] ok_pre,
    input logic [NUM_BANKS-1:0] ok_act,
    input logic [NUM_BANKS-1:0] ok_rd,
    input logic [NUM_BANKS-1:0] ok_wr
);
    localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

    logic no_cmd;
    assign no_cmd = (cmd_type == 3'd0) || (cmd_type > 3'd4);

    assert_reset_open_R1: assert property (@(posedge clk)
        rst |=> (&ok_pre && &ok_act && &ok_rd && &ok_wr));

    assert_act_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_type == 3'd1 && t_rrd > ONE) |=> (ok_act == '0));

    assert_col_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        ((cmd_type == 3'd3 || cmd_type == 3'd4) && t_ccd > ONE) |=> (ok_rd == '0 && ok_wr == '0));

    assert_idle_no_fall_R11: assert property (@(posedge clk) disable iff (rst)
        no_cmd |=> (&(ok_pre | ~$past(ok_pre)) && &(ok_act | ~$past(ok_act))
                    && &(ok_rd | ~$past(ok_rd)) && &(ok_wr | ~$past(ok_wr))));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_rcd_gate_R2: assert property (@(posedge clk) disable iff (rst)
            (cmd_type == 3'd1 && cmd_bank == BANK_W'(b) && t_rcd > ONE)
            |=> (!ok_rd[b] && !ok_wr[b]));

        assert_ras_gate_R3: assert property (@(posedge clk) disable iff (rst)
            (cmd_type == 3'd1 && cmd_bank == BANK_W'(b) && t_ras > ONE) |=> !ok_pre[b]);

        assert_rp_gate_R4: assert property (@(posedge clk) disable iff (rst)
            (cmd_type == 3'd2 && cmd_bank == BANK_W'(b) && t_rp > ONE) |=> !ok_act[b]);

        assert_wr_gate_R5: assert property (@(posedge clk) disable iff (rst)
            (cmd_type == 3'd4 && cmd_bank == BANK_W'(b) && t_wr > ONE) |=> !ok_pre[b]);
    end
endmodule

bind dram_timing_tracker dram_timing_tracker_checker #(
    .NUM_BANKS(NUM_BANKS), .TIMER_W(TIMER_W)
) u_checker (
    .clk(clk), .rst(rst), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_wr(t_wr),
    .t_rrd(t_rrd), .t_ccd(t_ccd),
    .ok_pre(ok_pre), .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr)
);

// File: tb/dram_timing_tracker_bench.sv
module dram_timing_tracker_bench;
    localparam int NB = 4;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd_type = 3'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic [TW-1:0] t_rcd = 6'd3, t_rp = 6'd2, t_ras = 6'd5;
    logic [TW-1:0] t_wr = 6'd4, t_rrd = 6'd2, t_ccd = 6'd2;
    logic [NB-1:0] ok_pre, ok_act, ok_rd, ok_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_timing_tracker #(.NUM_BANKS(NB), .TIMER_W(TW)) u_dram_timing_tracker (
        .clk(clk), .rst(rst), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
        .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_wr(t_wr),
        .t_rrd(t_rrd), .t_ccd(t_ccd),
        .ok_pre(ok_pre), .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr));

    // Row layout: [23:20] command code, [19:16] bank, then expected
    // {pre, act, rd, wr} masks one cycle after the row is issued.
    // Waits: rcd 3, rp 2, ras 5, wr 4, rrd 2, ccd 2.
    localparam int ROWS = 10;
    localparam logic [23:0] ROW_TAB [ROWS] = '{
        24'h10_E0EE,  // R2 R3 R6: activate bank 0
        24'h00_EFEE,  // R6: spacing over, rcd still pending
        24'h11_C0DD,  // R2 R6: activate bank 1
        24'h30_CF00,  // R7: read bank 0 closes column window
        24'h00_DFFF,  // R3: bank 0 active-minimum expires
        24'h40_CF00,  // R5 R7 R9: write bank 0, ras of bank 1 still open
        24'h00_EFFF,  // R9
        24'h21_EDFF,  // R4: precharge bank 1
        24'h00_FFFF,  // R4 R5
        24'h62_FFFF   // R11: unused code 6
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] flags();
        return {ok_pre, ok_act, ok_rd, ok_wr};
    endfunction

    task automatic issue(input logic [2:0] c, input logic [1:0] b);
        cmd_type = c;
        cmd_bank = b;
        @(negedge clk);
        cmd_type = 3'd0;
    endtask

    task automatic settle();
        cmd_type = 3'd0;
        repeat (12) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", flags(), 16'hFFFF);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", flags(), 16'hFFFF);

        for (int i = 0; i < ROWS; i++) begin
            cmd_type = ROW_TAB[i][22:20];
            cmd_bank = ROW_TAB[i][17:16];
            @(negedge clk);
            check($sformatf("R9 table row %0d", i), flags(), ROW_TAB[i][15:0]);
        end
        settle();

        // R2: read/write of bank 2 reopen exactly at cycle t_rcd
        issue(3'd1, 2'd2);
        for (int k = 1; k <= 4; k++) begin
            check($sformatf("R2 rcd k=%0d", k), {12'd0, ok_rd},
                  {12'd0, (k >= 3) ? 4'hF : 4'hB});
            check($sformatf("R3 ras k=%0d", k), {15'd0, ok_pre[2]}, {15'd0, k >= 5});
            @(negedge clk);
        end
        settle();

        // R8: zero and one mean no stall
        t_rcd = 6'd0; t_rrd = 6'd1;
        issue(3'd1, 2'd2);
        check("R8 rcd=0 read", {15'd0, ok_rd[2]}, 16'd1);
        check("R8 rrd=1 act", {12'd0, ok_act}, 16'h000F);
        t_rcd = 6'd1; t_ccd = 6'd1;
        issue(3'd1, 2'd1);
        check("R8 rcd=1 write", {15'd0, ok_wr[1]}, 16'd1);
        issue(3'd3, 2'd1);
        check("R8 ccd=1 read", {12'd0, ok_rd}, 16'h000F);
        t_rcd = 6'd3; t_rrd = 6'd2; t_ccd = 6'd2;
        settle();

        // R10: shorter reload must not cut a running wait
        t_wr = 6'd6;
        issue(3'd4, 2'd3);
        t_wr = 6'd2;
        issue(3'd4, 2'd3);
        for (int k = 2; k <= 6; k++) begin
            check($sformatf("R10 wr reload k=%0d", k), {15'd0, ok_pre[3]}, {15'd0, k >= 6});
            @(negedge clk);
        end
        t_wr = 6'd4;
        settle();

        // R12: parameter changed right after issue does not matter
        t_rp = 6'd4;
        issue(3'd2, 2'd2);
        t_rp = 6'd1;
        for (int k = 1; k <= 5; k++) begin
            check($sformatf("R12 rp k=%0d", k), {15'd0, ok_act[2]}, {15'd0, k >= 4});
            @(negedge clk);
        end
        t_rp = 6'd2;
        settle();

        // R11: unused codes load nothing
        issue(3'd5, 2'd0);
        issue(3'd7, 2'd1);
        check("R11 unused codes", flags(), 16'hFFFF);

        // R1: reset in the middle of activity
        issue(3'd1, 2'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-activity reset", flags(), 16'hFFFF);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after mid reset", flags(), 16'hFFFF);

        finished = 1'b1;
        report();
    end
endmodule